// File: doc/BRIEF.md
# Timer Interrupt Request and Vector Unit

This block sits beside the event logic of a general-purpose timer and turns its eleven event pulses into one bus interrupt request. Each event pulse sets a sticky pending flag. Each flag has its own enable bit in a mask word. When at least one flag is both pending and enabled, the block drives a programmed level from 1 to 7 on an encoded request output. Software clears a flag by writing a 1 to its bit.

When the CPU acknowledges an interrupt and presents a level that equals the programmed one, the block competes with other modules on a wired-OR arbitration line. It sends a 4-bit identifier one bit per cycle, most significant bit first, and drops out when it loses. If it wins, it presents an 8-bit vector for the rest of the acknowledge cycle. The vector is made of a 4-bit base and the number of the pending source. It is captured when the acknowledge begins and stays fixed until the acknowledge ends.

Source numbers, which are also the flag and mask bit positions: 0 to 2 are captures one to three, 3 to 6 are compares one to four, 7 is the shared capture-four/compare-five channel, 8 is counter overflow, 9 is accumulator overflow and 10 is accumulator input.

Top module: `tmr_irq_vec`

## Requirements
- R1: After reset, all three registers read back as zero, `irqLevel` is 0 and `vecValid` is 0.
- R2: Address 0 holds the mask word, with bit i enabling source i for i from 0 to 10. `wrByteEn[0]` writes bits 7:0 and `wrByteEn[1]` writes bits 15:8. Bits 15:11 always read 0.
- R3: Address 1 holds the flag word. A pulse on `srcEvent[i]` sets bit i. Writing a 1 to a bit clears it, and writing a 0 leaves it unchanged. When an event and a clear reach the same bit in the same cycle, the event wins and the bit ends up set.
- R4: Address 2 is the control word: request level in bits 2:0, vector base in bits 7:4 and arbitration identifier in bits 11:8. `irqLevel` equals the request level while any flag AND mask bit is 1, and is 0 otherwise. A request level of 0 keeps `irqLevel` at 0.
- R5: The block joins arbitration only when all of these hold on a cycle in which it is idle and `ackActive` is high: `ackLevel` equals the request level, the level is nonzero, the identifier is nonzero, and a request is pending. If it does not join, `arbDrive` and `vecValid` stay 0.
- R6: After joining, `arbDrive` presents identifier bits 3, 2, 1 and 0 on four consecutive cycles. `arbBusIn` is sampled on each of those cycles. If the block drives 0 and samples 1, it drops out and drives 0 from then on.
- R7: A block still in after all four bits raises `vecValid` and drives `vecOut` = {base, source number} on the next cycle. It holds both until the cycle after `ackActive` falls. A block that lost keeps `vecValid` and `vecOut` at 0.
- R8: When several enabled flags are pending, the lowest-numbered one supplies the source number.
- R9: The vector is captured on the cycle arbitration is joined. Events and register writes made after that do not change `vecOut` while it is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address (0 mask, 1 flag, 2 control) |
| wrByteEn | input | 2 | Byte enables for the write |
| wrData | input | 16 | Write data |
| rdAddr | input | 2 | Read address |
| rdData | output | 16 | Read data, combinational |
| srcEvent | input | 11 | Per-source event pulses |
| irqLevel | output | 3 | Encoded bus request level, 0 when none |
| ackActive | input | 1 | High for the whole acknowledge cycle |
| ackLevel | input | 3 | Level being acknowledged |
| arbBusIn | input | 1 | Wired-OR arbitration line as read back |
| arbDrive | output | 1 | This block's contribution to the arbitration line |
| vecValid | output | 1 | Block won and drives the vector |
| vecOut | output | 8 | Vector number, 0 unless vecValid |

## Verification
The bench plays every identifier against every other competitor identifier. A drop-out rule that compared bits the wrong way round, or sampled the line one bit late, would then either hand the vector to the lower identifier or let both contenders claim the bus. It sweeps each source as the lowest pending one, so a priority encoder that favours high numbers, or ignores the mask, shows up as a wrong source number in the vector. It also fires a lower-numbered event and rewrites the base in the middle of an acknowledge; a vector that is not captured would change under the CPU. Finally, it collides an event with a clear on the same bit, where a design that lets the clear win would lose an interrupt.

// File: rtl/tmr_irq_pkg.sv
`timescale 1ns/1ps
package tmr_irq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ARB, ST_WIN, ST_LOSE} arbState_t;

  typedef struct packed {
    logic latchVec;
    logic showVec;
  } ctrlStrobe_t;

  localparam logic [1:0] ADDR_MASK = 2'd0;
  localparam logic [1:0] ADDR_FLAG = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;
endpackage

// File: rtl/tmr_irq_dp.sv
`timescale 1ns/1ps
module tmr_irq_dp
  import tmr_irq_pkg::*;
#(
  parameter int NUM_SRC = 11,
  parameter int LVL_W   = 3,
  parameter int BASE_W  = 4,
  parameter int ARB_W   = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic [1:0]                wrAddr,
  input  logic [1:0]                wrByteEn,
  input  logic [15:0]               wrData,
  input  logic [1:0]                rdAddr,
  output logic [15:0]               rdData,
  input  logic [NUM_SRC-1:0]        srcEvent,
  input  ctrlStrobe_t               strobe,
  output logic [LVL_W-1:0]          level,
  output logic [ARB_W-1:0]          arbId,
  output logic                      anyPend,
  output logic [BASE_W+$clog2(NUM_SRC)-1:0] vecOut
);
  localparam int REG_W    = 16;
  localparam int NBYTE    = REG_W / 8;
  localparam int SRC_W    = $clog2(NUM_SRC);
  localparam int VEC_W    = BASE_W + SRC_W;
  localparam int LVL_LSB  = 0;
  localparam int BASE_LSB = 4;
  localparam int ARB_LSB  = 8;

  logic [REG_W-1:0]   byteMask;
  logic [NUM_SRC-1:0] maskReg;
  logic [NUM_SRC-1:0] flagReg;
  logic [BASE_W-1:0]  baseReg;
  logic [NUM_SRC-1:0] pend;
  logic [SRC_W-1:0]   srcNum;
  logic [VEC_W-1:0]   vecHold;
  logic [REG_W-1:0]   ctrlWord;
  logic [NUM_SRC-1:0] clrBits;
  logic [NUM_SRC-1:0] maskNext;

  for (genvar b = 0; b < NBYTE; b++) begin : g_byteMask
    assign byteMask[b*8 +: 8] = {8{wrByteEn[b]}};
  end

  assign clrBits  = (wrEn && wrAddr == ADDR_FLAG) ? (wrData[NUM_SRC-1:0] & byteMask[NUM_SRC-1:0]) : '0;
  assign maskNext = (maskReg & ~byteMask[NUM_SRC-1:0]) | (wrData[NUM_SRC-1:0] & byteMask[NUM_SRC-1:0]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg <= '0;
      flagReg <= '0;
      level   <= '0;
      baseReg <= '0;
      arbId   <= '0;
    end else begin
      flagReg <= (flagReg & ~clrBits) | srcEvent;
      if (wrEn && wrAddr == ADDR_MASK) maskReg <= maskNext;
      if (wrEn && wrAddr == ADDR_CTRL) begin
        if (wrByteEn[0]) begin
          level   <= wrData[LVL_LSB +: LVL_W];
          baseReg <= wrData[BASE_LSB +: BASE_W];
        end
        if (wrByteEn[1]) arbId <= wrData[ARB_LSB +: ARB_W];
      end
    end
  end

  assign pend    = flagReg & maskReg;
  assign anyPend = |pend;

  always_comb begin
    srcNum = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend[i]) srcNum = SRC_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) vecHold <= '0;
    else if (strobe.latchVec) vecHold <= {baseReg, srcNum};
  end

  assign vecOut = strobe.showVec ? vecHold : '0;

  always_comb begin
    ctrlWord = '0;
    ctrlWord[LVL_LSB +: LVL_W]   = level;
    ctrlWord[BASE_LSB +: BASE_W] = baseReg;
    ctrlWord[ARB_LSB +: ARB_W]   = arbId;
  end

  always_comb begin
    unique case (rdAddr)
      ADDR_MASK: rdData = REG_W'(maskReg);
      ADDR_FLAG: rdData = REG_W'(flagReg);
      ADDR_CTRL: rdData = ctrlWord;
      default:   rdData = '0;
    endcase
  end

  assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (($past(srcEvent) & ~flagReg) == '0));

  assert_vec_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.showVec && $past(strobe.showVec)) |-> $stable(vecOut));
endmodule

// File: rtl/tmr_irq_ctrl.sv
`timescale 1ns/1ps
module tmr_irq_ctrl
  import tmr_irq_pkg::*;
#(
  parameter int LVL_W = 3,
  parameter int ARB_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ackActive,
  input  logic [LVL_W-1:0] ackLevel,
  input  logic             arbBusIn,
  input  logic [LVL_W-1:0] level,
  input  logic [ARB_W-1:0] arbId,
  input  logic             anyPend,
  output ctrlStrobe_t      strobe,
  output logic             arbDrive,
  output logic             vecValid
);
  localparam int IDX_W = (ARB_W > 1) ? $clog2(ARB_W) : 1;

  arbState_t        state;
  logic [IDX_W-1:0] bitIdx;
  logic             joinOk;

  assign joinOk = ackActive && anyPend && (ackLevel == level) &&
                  (level != '0) && (arbId != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitIdx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (joinOk) begin
          state  <= ST_ARB;
          bitIdx <= IDX_W'(ARB_W - 1);
        end
        ST_ARB: begin
          if (!ackActive)                       state <= ST_IDLE;
          else if (!arbId[bitIdx] && arbBusIn) state <= ST_LOSE;
          else if (bitIdx == '0)               state <= ST_WIN;
          else                                 bitIdx <= bitIdx - 1'b1;
        end
        ST_WIN, ST_LOSE: if (!ackActive) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign strobe.latchVec = (state == ST_IDLE) && joinOk;
  assign strobe.showVec  = (state == ST_WIN);
  assign arbDrive        = (state == ST_ARB) && arbId[bitIdx];
  assign vecValid        = strobe.showVec;

  assert_join_level_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && ackLevel != level) |=> (state != ST_ARB));

  assert_dropout_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ARB && !arbDrive && arbBusIn && ackActive) |=> (!arbDrive && !vecValid));

  assert_vec_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    (vecValid && !ackActive) |=> !vecValid);
endmodule

// File: rtl/tmr_irq_vec.sv
`timescale 1ns/1ps
module tmr_irq_vec
  import tmr_irq_pkg::*;
#(
  parameter int NUM_SRC = 11,
  parameter int LVL_W   = 3,
  parameter int BASE_W  = 4,
  parameter int ARB_W   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [1:0]          wrAddr,
  input  logic [1:0]          wrByteEn,
  input  logic [15:0]         wrData,
  input  logic [1:0]          rdAddr,
  output logic [15:0]         rdData,
  input  logic [NUM_SRC-1:0]  srcEvent,
  output logic [LVL_W-1:0]    irqLevel,
  input  logic                ackActive,
  input  logic [LVL_W-1:0]    ackLevel,
  input  logic                arbBusIn,
  output logic                arbDrive,
  output logic                vecValid,
  output logic [BASE_W+$clog2(NUM_SRC)-1:0] vecOut
);
  ctrlStrobe_t      strobe;
  logic [LVL_W-1:0] level;
  logic [ARB_W-1:0] arbId;
  logic             anyPend;

  tmr_irq_dp #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .BASE_W(BASE_W), .ARB_W(ARB_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrByteEn(wrByteEn),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .srcEvent(srcEvent),
    .strobe(strobe), .level(level), .arbId(arbId), .anyPend(anyPend), .vecOut(vecOut)
  );

  tmr_irq_ctrl #(.LVL_W(LVL_W), .ARB_W(ARB_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .ackActive(ackActive), .ackLevel(ackLevel),
    .arbBusIn(arbBusIn), .level(level), .arbId(arbId), .anyPend(anyPend),
    .strobe(strobe), .arbDrive(arbDrive), .vecValid(vecValid)
  );

  assign irqLevel = anyPend ? level : '0;
endmodule

// File: tb/tmr_irq_vec_tb.sv
`timescale 1ns/1ps
module tmr_irq_vec_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [1:0]  wrByteEn = '0;
  logic [15:0] wrData = '0;
  logic [1:0]  rdAddr = '0;
  logic [15:0] rdData;
  logic [10:0] srcEvent = '0;
  logic [2:0]  irqLevel;
  logic        ackActive = 1'b0;
  logic [2:0]  ackLevel = '0;
  logic        arbBusIn = 1'b0;
  logic        arbDrive;
  logic        vecValid;
  logic [7:0]  vecOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tmr_irq_vec u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrByteEn(wrByteEn),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .srcEvent(srcEvent),
    .irqLevel(irqLevel), .ackActive(ackActive), .ackLevel(ackLevel),
    .arbBusIn(arbBusIn), .arbDrive(arbDrive), .vecValid(vecValid), .vecOut(vecOut)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [1:0] be, input logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrByteEn = be; wrData = d;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    rdAddr = a; #0.5; v = rdData;
  endtask

  task automatic pulse(input logic [10:0] ev);
    srcEvent = ev;
    @(posedge clk); @(negedge clk);
    srcEvent = '0;
  endtask

  task automatic runArb(input logic [3:0] myId, input logic [3:0] comp, input bit expJoin,
                        input logic [7:0] expVec, input bit disturb, input string tag);
    logic [3:0] hi;
    bit stillIn;
    bit win;
    hi = (myId > comp) ? myId : comp;
    ackActive = 1'b1;
    @(posedge clk); @(negedge clk);
    stillIn = expJoin;
    for (int k = 3; k >= 0; k--) begin
      check(arbDrive == (stillIn & myId[k]), {tag, " arbDrive"}, arbDrive, stillIn & myId[k]);
      arbBusIn = expJoin ? hi[k] : comp[k];
      if (disturb && k == 3) srcEvent = 11'h001;
      @(posedge clk); @(negedge clk);
      srcEvent = '0; arbBusIn = 1'b0;
      if (stillIn && !myId[k] && hi[k]) stillIn = 1'b0;
    end
    win = expJoin && stillIn;
    check(vecValid == win, {tag, " vecValid"}, vecValid, win);
    check(vecOut == (win ? expVec : 8'h00), {tag, " vecOut"}, vecOut, win ? expVec : 8'h00);
    if (disturb) begin
      wr(2'd2, 2'b01, 16'h0000);
      pulse(11'h003);
      check(vecOut == expVec, "R9 vector frozen after writes/events", vecOut, expVec);
      check(vecValid == 1'b1, "R9 still valid during ack", vecValid, 1);
    end
    ackActive = 1'b0;
    @(posedge clk); @(negedge clk);
    check(vecValid == 1'b0 && vecOut == 8'h00, {tag, " release R7"}, vecOut, 0);
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 3; a++) begin
      rd(2'(a), v);
      check(v == 16'h0, "R1 register reset", v, 0);
    end
    check(irqLevel == 3'd0 && vecValid == 1'b0, "R1 outputs at reset", irqLevel, 0);

    // R2 byte-granular mask writes
    wr(2'd0, 2'b01, 16'hFFFF); rd(2'd0, v);
    check(v == 16'h00FF, "R2 low byte only", v, 16'h00FF);
    wr(2'd0, 2'b10, 16'hFFFF); rd(2'd0, v);
    check(v == 16'h07FF, "R2 high byte, unused bits zero", v, 16'h07FF);
    wr(2'd0, 2'b00, 16'h0000); rd(2'd0, v);
    check(v == 16'h07FF, "R2 no byte enable no change", v, 16'h07FF);
    wr(2'd0, 2'b11, 16'h0000); rd(2'd0, v);
    check(v == 16'h0000, "R2 word write", v, 0);

    // R3 flag set, write-0 no effect, write-1 clear, collision
    for (int i = 0; i < 11; i++) begin
      pulse(11'(1 << i)); rd(2'd1, v);
      check(v == 16'(1 << i), "R3 event sets flag", v, 1 << i);
      wr(2'd1, 2'b11, 16'h0000); rd(2'd1, v);
      check(v == 16'(1 << i), "R3 write 0 keeps flag", v, 1 << i);
      wr(2'd1, 2'b11, 16'(1 << i)); rd(2'd1, v);
      check(v == 16'h0, "R3 write 1 clears", v, 0);
      srcEvent = 11'(1 << i);
      wr(2'd1, 2'b11, 16'(1 << i));
      srcEvent = '0; rd(2'd1, v);
      check(v == 16'(1 << i), "R3 event beats clear", v, 1 << i);
      wr(2'd1, 2'b11, 16'hFFFF);
    end

    // R4 request level sweep
    wr(2'd0, 2'b11, 16'h07FF);
    pulse(11'h020);
    for (int l = 0; l < 8; l++) begin
      wr(2'd2, 2'b11, 16'(l));
      check(irqLevel == 3'(l), "R4 level follows field", irqLevel, l);
    end
    wr(2'd0, 2'b11, 16'h0000);
    check(irqLevel == 3'd0, "R4 masked gives no request", irqLevel, 0);
    wr(2'd1, 2'b11, 16'hFFFF);

    // R8 lowest pending source supplies the vector
    wr(2'd0, 2'b11, 16'h07FF);
    wr(2'd2, 2'b11, 16'h0FA5);
    rd(2'd2, v);
    check(v == 16'h0FA5, "R4 control readback", v, 16'h0FA5);
    ackLevel = 3'd5;
    for (int i = 0; i < 11; i++) begin
      pulse(11'h7FF & ~11'((1 << i) - 1));
      runArb(4'hF, 4'h0, 1'b1, {4'hA, 4'(i)}, 1'b0, "R8 lowest source");
      wr(2'd1, 2'b11, 16'hFFFF);
    end
    wr(2'd0, 2'b11, 16'h07FE);
    pulse(11'h009);
    runArb(4'hF, 4'h0, 1'b1, 8'hA3, 1'b0, "R8 masked source skipped");

    // R5 conditions for joining
    for (int a = 0; a < 8; a++) begin
      if (a != 5) begin
        ackLevel = 3'(a);
        runArb(4'hF, 4'h3, 1'b0, 8'h00, 1'b0, "R5 level mismatch");
      end
    end
    ackLevel = 3'd5;
    wr(2'd2, 2'b11, 16'h00A5);
    runArb(4'h0, 4'h3, 1'b0, 8'h00, 1'b0, "R5 zero identifier");
    wr(2'd2, 2'b11, 16'h0FA5);
    wr(2'd1, 2'b11, 16'hFFFF);
    runArb(4'hF, 4'h3, 1'b0, 8'h00, 1'b0, "R5 nothing pending");
    wr(2'd2, 2'b11, 16'h0FA0);
    pulse(11'h001);
    ackLevel = 3'd0;
    runArb(4'hF, 4'h3, 1'b0, 8'h00, 1'b0, "R5 level zero");
    wr(2'd1, 2'b11, 16'hFFFF);

    // R6 / R7 arbitration sweep over all identifier pairs
    wr(2'd0, 2'b11, 16'h07FF);
    pulse(11'h004);
    ackLevel = 3'd3;
    for (int m = 1; m < 16; m++) begin
      wr(2'd2, 2'b11, 16'((m << 8) | 16'h0063));
      for (int c = 0; c < 16; c++) begin
        if (c != m) runArb(4'(m), 4'(c), 1'b1, 8'h62, 1'b0, "R6 R7 arbitration");
      end
    end
    wr(2'd1, 2'b11, 16'hFFFF);

    // R9 vector frozen while driven
    wr(2'd2, 2'b11, 16'h09B3);
    pulse(11'h010);
    runArb(4'h9, 4'h3, 1'b1, 8'hB4, 1'b1, "R9 capture");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule